// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

This adapter sits between a big-endian processor-side bus and a register file whose registers come in different native widths. The requester issues byte, halfword or word reads and writes. The adapter looks up the native width of the 4-byte group being addressed, then turns the request into a short series of native-width operations on a downstream register port. That port carries one operation per cycle, and its read data is returned in the same cycle.

Three cases arise. When the request is narrower than the register, a read fetches the whole register and picks out the addressed lanes. A narrow write instead reads the register, merges in the new lanes and writes the result back. When the request is wider than the register, it is split into consecutive native operations in ascending address order, and the lowest address carries the most significant data.

Four fixed 32-byte windows of the space are steered to separate sub-peripheral targets, with a select code and a window-relative address. Unmapped groups and out-of-range addresses finish at once with an error flag.

Top module: `regbus_width_adapter`

## Requirements
- R1: While and after reset, with no request outstanding, `req_ready` is 1 and both `resp_valid` and `dn_valid` are 0.
- R2: Only bits 9:0 of `req_addr` are used. An address that differs only above bit 9 behaves the same as its masked value.
- R3: A request is an error if its masked address has bit 9 set, if its group has width code 0, or if `req_size` is 3. The adapter issues no downstream operation, so writes are discarded. In the cycle after acceptance, `resp_valid`=1, `resp_err`=1 and `resp_rdata`=0.
- R4: `WIDTH_MAP` holds a 2-bit code for group g = addr[8:2] at bits [2g+1:2g]: 0 = unimplemented, 1 = byte, 2 = halfword, 3 = word. The default map is byte for 0x000-0x03F, 0x140-0x15F and 0x180-0x19F; halfword for 0x040-0x07F and 0x100-0x13F; word for 0x080-0x0BF and 0x160-0x17F; unimplemented elsewhere.
- R5: A request whose size equals the native width becomes exactly one downstream operation at the same address and in the same direction.
- R6: A read narrower than the register becomes one native read at the register-aligned address. The addressed bytes are taken big-endian: the lowest address is the most significant byte of the native value.
- R7: A write narrower than the register becomes a native read followed by a native write at the register-aligned address. The write replaces only the addressed bytes and keeps the others.
- R8: A request wider than the register becomes size/width native operations at ascending addresses, in the request's direction. The lowest address carries the most significant part of the data.
- R9: Operations to 0x100-0x11F, 0x120-0x13F, 0x140-0x15F and 0x180-0x19F drive `dn_sel` = 1, 2, 3 and 4 respectively, with `dn_addr` set to the offset within the window. All other operations drive `dn_sel` = 0 and the full masked address.
- R10: `req_ready` is 0 from acceptance until the response. A request needing n downstream operations drives them in n consecutive cycles, and `resp_valid` pulses in the following cycle.
- R11: `req_size` and `dn_size` encode 0 = byte, 1 = halfword, 2 = word. Write data and read data are right-justified in their 32-bit buses, and request data above the request size is ignored. `dn_size` always equals the group's native width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Request size code |
| req_addr | input | ADDR_W | Byte address (bits 9:0 used) |
| req_wdata | input | 32 | Write data, right-justified |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion is an error |
| resp_rdata | output | 32 | Read data, right-justified; 0 for writes and errors |
| dn_valid | output | 1 | Downstream operation this cycle |
| dn_write | output | 1 | Downstream operation is a write |
| dn_size | output | 2 | Downstream native size code |
| dn_sel | output | 3 | Target select: 0 local, 1-4 windows |
| dn_addr | output | 10 | Downstream address, window-relative when selected |
| dn_wdata | output | 32 | Downstream write data, right-justified |
| dn_rdata | input | 32 | Downstream read data, same cycle, right-justified |

## Verification
The properties assume that every request is naturally aligned to its size. They also assume the downstream side answers each read in the same cycle it is issued. Under those conditions every generated operation stays inside one 4-byte group and inside its window. The bench walks every aligned address in the 1 KiB masked space at each size, with varied upper address bits, so it never issues a misaligned request. Its register model returns data combinationally from a byte array, which satisfies the same-cycle assumption.

// File: rtl/regbus_width_adapter.sv
module regbus_width_adapter #(
  parameter int ADDR_W = 32,
  parameter logic [255:0] WIDTH_MAP =
    256'h000000000000_5555_FFFF_5555_AAAAAAAA_00000000_FFFFFFFF_AAAAAAAA_55555555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       resp_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [1:0]        dn_size,
  output logic [2:0]        dn_sel,
  output logic [9:0]        dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);

  logic        busy, wr_q;
  logic [9:0]  a_q;
  logic [1:0]  sz_q, nw_q, k_q, last_q;
  logic [31:0] wd_q, acc_q;

  logic unused_hi;
  assign unused_hi = ^req_addr[ADDR_W-1:10];

  wire [9:0] in_a    = req_addr[9:0];
  wire [1:0] in_code = WIDTH_MAP[{in_a[8:2], 1'b0} +: 2];
  wire       in_err  = in_a[9] | (in_code == 2'd0) | (req_size == 2'd3);
  wire [1:0] in_nw   = in_code - 2'd1;

  logic [1:0] in_last;
  always_comb begin
    if (req_size > in_nw)
      in_last = (req_size - in_nw == 2'd1) ? 2'd1 : 2'd3;
    else if (req_size < in_nw && req_write)
      in_last = 2'd1;
    else
      in_last = 2'd0;
  end

  wire split = sz_q > nw_q;
  wire rmw   = (sz_q < nw_q) & wr_q;

  function automatic logic [31:0] lane_mask(input logic [1:0] code);
    return (code == 2'd0) ? 32'h0000_00FF :
           (code == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  wire [31:0] wmask = lane_mask(nw_q);
  wire [31:0] smask = lane_mask(sz_q);

  wire [9:0] op_a = split ? a_q + ({8'd0, k_q} << nw_q)
                          : a_q & ~((10'd1 << nw_q) - 10'd1);

  wire [2:0] natb = 3'd1 << nw_q;
  wire [2:0] szb  = 3'd1 << sz_q;
  wire [2:0] off  = {1'b0, a_q[1:0]} & (natb - 3'd1);
  wire [2:0] shb  = natb - szb - off;
  wire [4:0] lsh  = {shb[1:0], 3'b000};
  wire [1:0] rem  = last_q - k_q;
  wire [4:0] dsh  = 5'({3'd0, rem} << ({1'b0, nw_q} + 3'd3));

  wire [31:0] ext    = (dn_rdata >> lsh) & smask;
  wire [31:0] merged = (dn_rdata & ~(smask << lsh)) | ((wd_q & smask) << lsh);

  logic [31:0] acc_nx;
  always_comb begin
    if (split)    acc_nx = (acc_q << (6'd8 << nw_q)) | (dn_rdata & wmask);
    else if (rmw) acc_nx = merged;
    else          acc_nx = ext;
  end

  always_comb begin
    dn_sel  = 3'd0;
    dn_addr = op_a;
    case (op_a[9:5])
      5'b01000: dn_sel = 3'd1;
      5'b01001: dn_sel = 3'd2;
      5'b01010: dn_sel = 3'd3;
      5'b01100: dn_sel = 3'd4;
      default:  dn_sel = 3'd0;
    endcase
    if (dn_sel != 3'd0) dn_addr = {5'd0, op_a[4:0]};
  end

  assign req_ready = ~busy;
  assign dn_valid  = busy;
  assign dn_size   = nw_q;
  assign dn_write  = busy & (rmw ? (k_q == 2'd1) : wr_q);
  assign dn_wdata  = rmw   ? acc_q :
                     split ? (wd_q >> dsh) & wmask : wd_q & wmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
      wr_q       <= 1'b0;
      a_q        <= '0;
      sz_q       <= '0;
      nw_q       <= '0;
      k_q        <= '0;
      last_q     <= '0;
      wd_q       <= '0;
      acc_q      <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (in_err) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            resp_rdata <= '0;
          end else begin
            busy   <= 1'b1;
            wr_q   <= req_write;
            a_q    <= in_a;
            sz_q   <= req_size;
            nw_q   <= in_nw;
            last_q <= in_last;
            wd_q   <= req_wdata;
            k_q    <= '0;
            acc_q  <= '0;
          end
        end
      end else begin
        acc_q <= acc_nx;
        if (k_q == last_q) begin
          busy       <= 1'b0;
          resp_valid <= 1'b1;
          resp_err   <= 1'b0;
          resp_rdata <= wr_q ? 32'd0 : acc_nx;
        end else begin
          k_q <= k_q + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/regbus_width_adapter_chk.sv
module regbus_width_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_err,
  input logic [31:0] resp_rdata,
  input logic        dn_valid,
  input logic [1:0]  dn_size,
  input logic [2:0]  dn_sel,
  input logic [9:0]  dn_addr
);

  // R3
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_err |-> resp_rdata == 32'd0);

  // R11
  native_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_size != 2'd3);

  // R9
  window_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_sel != 3'd0 |-> dn_sel <= 3'd4 && dn_addr < 10'd32);

  // R9
  local_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_sel == 3'd0 |-> dn_addr < 10'h200 &&
      !(dn_addr >= 10'h100 && dn_addr < 10'h160) &&
      !(dn_addr >= 10'h180 && dn_addr < 10'h1A0));

  // R6
  op_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_addr & ((10'd1 << dn_size) - 10'd1)) == 10'd0);

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !req_ready);

  // R10
  ready_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> resp_valid && !resp_err);

endmodule

bind regbus_width_adapter regbus_width_adapter_chk i_chk (.*);

// File: tb/test_regbus_width_adapter.sv
module test_regbus_width_adapter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic        dn_valid, dn_write;
  logic [1:0]  dn_size;
  logic [2:0]  dn_sel;
  logic [9:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] mem  [0:511];
  logic [7:0] refm [0:511];

  always #10 clk = ~clk;

  regbus_width_adapter i_regbus_width_adapter (.*);

  function automatic int gw(int a);
    int g;
    if (a >= 512) return 0;
    g = a >> 2;
    if (g < 16)  return 1;
    if (g < 32)  return 2;
    if (g < 48)  return 4;
    if (g < 64)  return 0;
    if (g < 80)  return 2;
    if (g < 88)  return 1;
    if (g < 96)  return 4;
    if (g < 104) return 1;
    return 0;
  endfunction

  function automatic int wbase(int sel);
    case (sel)
      1: return 'h100;
      2: return 'h120;
      3: return 'h140;
      4: return 'h180;
      default: return 0;
    endcase
  endfunction

  function automatic int wsel(int fa);
    if (fa >= 'h100 && fa < 'h120) return 1;
    if (fa >= 'h120 && fa < 'h140) return 2;
    if (fa >= 'h140 && fa < 'h160) return 3;
    if (fa >= 'h180 && fa < 'h1A0) return 4;
    return 0;
  endfunction

  function automatic int lg(int b);
    return (b == 1) ? 0 : (b == 2) ? 1 : 2;
  endfunction

  always_comb begin
    int fa;
    fa = wbase(int'(dn_sel)) + int'(dn_addr);
    dn_rdata = '0;
    for (int i = 0; i < (1 << dn_size); i++)
      dn_rdata = {dn_rdata[23:0], mem[(fa + i) & 511]};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'h00;
    end else if (dn_valid && dn_write) begin
      int fa, nb;
      fa = wbase(int'(dn_sel)) + int'(dn_addr);
      nb = 1 << dn_size;
      for (int i = 0; i < nb; i++)
        mem[(fa + i) & 511] <= dn_wdata[(nb - 1 - i) * 8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit wr, input int szl, input logic [31:0] addr,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output bit er);
    int a, w, s, n, k, ea, esel;
    bit eerr, got, rdy_bad;
    int opa [4];
    bit opw [4];
    string t;
    logic [31:0] exp, grp_act, grp_exp;
    a = int'(addr[9:0]);
    w = gw(a);
    s = 1 << szl;
    eerr = (szl == 3) || (w == 0);
    rd = '0;
    er = 1'b0;
    n = 0;
    if (eerr) t = "R3";
    else if (s == w) t = "R5";
    else if (s < w) t = wr ? "R7" : "R6";
    else t = "R8";
    if (!eerr) begin
      if (s > w) begin
        n = s / w;
        for (int i = 0; i < n; i++) begin opa[i] = a + i * w; opw[i] = wr; end
      end else if (s < w && wr) begin
        n = 2;
        opa[0] = a & ~(w - 1); opw[0] = 1'b0;
        opa[1] = a & ~(w - 1); opw[1] = 1'b1;
      end else begin
        n = 1;
        opa[0] = a & ~(w - 1); opw[0] = wr;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(szl);
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; got = 1'b0; rdy_bad = 1'b0;
    for (int c = 1; c <= 12 && !got; c++) begin
      if (resp_valid) begin
        got = 1'b1;
        rd = resp_rdata;
        er = resp_err;
        chk(c == n + 1, {t, " R10 latency"}, c, n + 1);
      end else begin
        if (req_ready) rdy_bad = 1'b1;
        if (dn_valid) begin
          if (k < 4 && k < n) begin
            ea = opa[k];
            esel = wsel(ea);
            chk({dn_sel, dn_addr, dn_size, dn_write} ==
                {3'(esel), 10'(ea - wbase(esel)), 2'(lg(w)), opw[k]},
                {t, " R4 R9 R11 op"},
                {dn_sel, dn_addr, dn_size, dn_write},
                {3'(esel), 10'(ea - wbase(esel)), 2'(lg(w)), opw[k]});
          end
          k++;
        end
        @(negedge clk);
      end
    end
    chk(got, {t, " R10 response"}, got, 1);
    chk(!rdy_bad, {t, " R10 ready"}, rdy_bad, 0);
    chk(k == n, {t, " op count"}, k, n);
    chk(er == eerr, {t, " error flag"}, er, eerr);
    if (!wr) begin
      exp = '0;
      if (!eerr) for (int i = 0; i < s; i++) exp = {exp[23:0], refm[a + i]};
      chk(rd == exp, {t, " R11 read data"}, rd, exp);
    end else begin
      if (!eerr)
        for (int i = 0; i < s; i++) refm[a + i] = wd[(s - 1 - i) * 8 +: 8];
      if (a < 512) begin
        grp_act = {mem[(a & ~3)], mem[(a & ~3) + 1], mem[(a & ~3) + 2], mem[(a & ~3) + 3]};
        grp_exp = {refm[(a & ~3)], refm[(a & ~3) + 1], refm[(a & ~3) + 2], refm[(a & ~3) + 3]};
        chk(grp_act == grp_exp, {t, " R11 group contents"}, grp_act, grp_exp);
      end
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    bit er;
    for (int i = 0; i < 512; i++) refm[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1
    chk(req_ready && !resp_valid && !dn_valid, "R1 in reset",
        {req_ready, resp_valid, dn_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready && !resp_valid && !dn_valid, "R1 after reset",
        {req_ready, resp_valid, dn_valid}, 3'b100);

    for (int szl = 0; szl < 3; szl++) begin
      for (int a = 0; a < 1024; a += (1 << szl)) begin
        logic [31:0] ad, wd;
        ad = {22'(a * 37 + szl), 10'(a)};
        wd = (32'h9E37_79B9 * 32'(a + 1)) ^ (32'(szl) << 28);
        do_access(1'b1, szl, ad, wd, rd, er);
        do_access(1'b0, szl, ad ^ 32'hFFFF_FC00, 32'h0, rd, er);
      end
    end

    // R8 whole word across four byte registers read back byte by byte
    do_access(1'b1, 2, 32'h0000_0144, 32'h1122_3344, rd, er);
    for (int i = 0; i < 4; i++) begin
      do_access(1'b0, 0, 32'h0000_0144 + 32'(i), 32'h0, rd, er);
      chk(rd == 32'(8'h11 + 8'(i * 8'h11)), "R8 byte order", rd, 8'h11 + i * 8'h11);
    end

    // R7 byte write into word register keeps other lanes
    do_access(1'b1, 2, 32'h0000_0088, 32'hA0B0_C0D0, rd, er);
    do_access(1'b1, 0, 32'h0000_008A, 32'hFFFF_FF5E, rd, er);
    do_access(1'b0, 2, 32'h0000_0088, 32'h0, rd, er);
    chk(rd == 32'hA0B0_5ED0, "R7 merged word", rd, 32'hA0B0_5ED0);

    // R2 high address bits ignored
    do_access(1'b1, 1, 32'hFFFF_FC40, 32'h0000_55AA, rd, er);
    do_access(1'b0, 1, 32'h0000_0040, 32'h0, rd, er);
    chk(rd == 32'h0000_55AA && !er, "R2 masked alias", rd, 32'h55AA);

    // R3 size code 3 and out-of-range access
    do_access(1'b0, 3, 32'h0000_0000, 32'h0, rd, er);
    chk(er && rd == 0, "R3 bad size", {er, rd}, {1'b1, 32'h0});
    do_access(1'b1, 2, 32'h0000_0A00, 32'hDEAD_BEEF, rd, er);
    chk(er, "R3 beyond 0x1FF", er, 1);

    // R1 idle state after all traffic
    @(negedge clk);
    chk(req_ready && !dn_valid, "R1 idle", {req_ready, dn_valid}, 2'b10);

    for (int i = 0; i < 512; i += 4) begin
      chk({mem[i], mem[i + 1], mem[i + 2], mem[i + 3]} ==
          {refm[i], refm[i + 1], refm[i + 2], refm[i + 3]}, "R3 R7 R8 final image",
          {mem[i], mem[i + 1], mem[i + 2], mem[i + 3]},
          {refm[i], refm[i + 1], refm[i + 2], refm[i + 3]});
    end
    finish_run();
  end

endmodule